// File: doc/BRIEF.md
# Nibble-Serial Instruction Fetch Sequencer

This block paces a small 4-bit processor through a fixed machine cycle of eight clock slots on a shared 4-bit bus. Every slot has a fixed job. In three slots the sequencer puts the 12-bit program address on the bus, one nibble per slot. In two slots it takes the instruction byte back from memory, one nibble per slot. The last three slots are for execution. A one-clock sync pulse in the final execution slot tells the attached memories that a new address is about to start.

The program counter advances by one at the end of the last address slot, so the next cycle sends the following address. The first instruction nibble is held as the opcode. The second is held as the operand. Both stay visible to the decode logic, which sits outside this block. The bus is modelled as separate in and out lines plus an output enable. An external tri-state driver joins them.

A reset request only clears the block once it has been held for a full minimum time. While reset is high the machine halts. A reset that is too short leaves all state as it was, so the sequence carries on from the slot where it stopped.

Top module: `fetch_seq_top`

## Requirements
- R1: While `rstReq` is low, `phaseOut` advances by one on every clock and wraps from 7 to 0. While `rstReq` is high, `phaseOut` holds its value, except when a clear occurs.
- R2: `syncOut` is high only while `phaseOut` is 7 and `rstReq` is low. It is therefore a single-clock pulse, and phase 0 follows it.
- R3: `busOe` is high only in phases 0, 1 and 2 with `rstReq` low. In those phases `busOut` carries the program address bits [3:0], [7:4] and [11:8] in that order.
- R4: The program address rises by one at the end of phase 2 of every cycle and wraps from 4095 to 0. The next cycle sends the new value.
- R5: `opcodeOut` loads `busIn` at the clock edge that ends phase 3. `operandOut` loads `busIn` at the edge that ends phase 4. Neither changes at any other edge while reset is low.
- R6: Holding `rstReq` high for 64 consecutive clock edges clears the program address, `opcodeOut` and `operandOut` to 0 and sets `phaseOut` to 7. After release, sync comes first and then address 0.
- R7: A reset held for 63 or fewer edges clears nothing. After release, phase, address, opcode and operand carry on from their halted values.
- R8: The hold count restarts whenever `rstReq` is low at an edge. Two short pulses separated by one low clock do not clear, even if their total length exceeds 64.
- R9: While `rstReq` is high, `busOe` and `syncOut` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single-phase clock |
| rstReq | input | 1 | Reset request, active high, effective after the minimum hold |
| busIn | input | 4 | Nibble returned by memory on the shared bus |
| busOut | output | 4 | Address nibble driven onto the shared bus |
| busOe | output | 1 | Output enable for the bus driver |
| syncOut | output | 1 | Start-of-cycle marker |
| opcodeOut | output | 4 | Captured first instruction nibble |
| operandOut | output | 4 | Captured second instruction nibble |
| phaseOut | output | 3 | Current slot of the machine cycle |

## Verification
The hardest cases to reach are the reset boundaries and the address wrap. A reset held for exactly 63 edges must leave state alone, while 64 must clear. Two near-threshold pulses split by a single low clock must not add up. The stimulus stops the machine in phase 5, where a clear would be visible, and applies each of these pulse shapes. It then compares phase and nibbles against values saved before the pulse. The address wrap needs more than 4096 machine cycles of free running, and the bench runs that long while its model checks every address nibble.

// File: rtl/fetch_seq_pkg.sv
`timescale 1ns/1ps
package fetch_seq_pkg;
  // Per-clock commands from the slot controller to the datapath.
  typedef struct packed {
    logic       clearAll;
    logic       incPc;
    logic       loadOpc;
    logic       loadOpr;
    logic       driveEn;
    logic [3:0] nibIdx;
  } seqStrobe_t;
endpackage

// File: rtl/fetch_seq_ctrl.sv
`timescale 1ns/1ps
module fetch_seq_ctrl
  import fetch_seq_pkg::*;
#(
  parameter int SLOTS     = 8,
  parameter int ADDR_NIBS = 3,
  parameter int HOLD_CLKS = 64,
  parameter int PH_W      = 3
) (
  input  logic            clk,
  input  logic            rstReq,
  output seqStrobe_t      strobe,
  output logic [PH_W-1:0] phase,
  output logic            syncOut
);
  localparam int CNT_W = $clog2(HOLD_CLKS + 1);
  localparam logic [CNT_W-1:0] HOLD_MAX  = CNT_W'(HOLD_CLKS);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CLKS - 1);
  localparam logic [PH_W-1:0]  LAST_PH   = PH_W'(SLOTS - 1);
  localparam logic [PH_W-1:0]  INC_PH    = PH_W'(ADDR_NIBS - 1);
  localparam logic [PH_W-1:0]  OPC_PH    = PH_W'(ADDR_NIBS);
  localparam logic [PH_W-1:0]  OPR_PH    = PH_W'(ADDR_NIBS + 1);

  logic [CNT_W-1:0] holdCnt;
  logic             clearNow;
  logic             running;

  assign running  = !rstReq;
  assign clearNow = rstReq && (holdCnt == HOLD_LAST);

  // Consecutive-edge reset counter; any low edge restarts it.
  always_ff @(posedge clk) begin
    if (!rstReq)
      holdCnt <= '0;
    else if (holdCnt != HOLD_MAX)
      holdCnt <= holdCnt + 1'b1;
  end

  // Slot counter: halts under reset, parks on the sync slot after a clear.
  always_ff @(posedge clk) begin
    if (clearNow)
      phase <= LAST_PH;
    else if (running)
      phase <= (phase == LAST_PH) ? '0 : phase + 1'b1;
  end

  always_comb begin
    strobe          = '0;
    strobe.clearAll = clearNow;
    strobe.incPc    = running && (phase == INC_PH);
    strobe.loadOpc  = running && (phase == OPC_PH);
    strobe.loadOpr  = running && (phase == OPR_PH);
    strobe.driveEn  = running && (phase < OPC_PH);
    strobe.nibIdx   = 4'(phase);
  end

  assign syncOut = running && (phase == LAST_PH);
endmodule

// File: rtl/fetch_seq_dpath.sv
`timescale 1ns/1ps
module fetch_seq_dpath
  import fetch_seq_pkg::*;
#(
  parameter int NIB_W     = 4,
  parameter int ADDR_W    = 12,
  parameter int ADDR_NIBS = 3
) (
  input  logic             clk,
  input  seqStrobe_t       strobe,
  input  logic [NIB_W-1:0] busIn,
  output logic [NIB_W-1:0] busOut,
  output logic [NIB_W-1:0] opcodeOut,
  output logic [NIB_W-1:0] operandOut
);
  logic [ADDR_W-1:0] pcReg;
  logic [NIB_W-1:0]  pcNib [ADDR_NIBS];

  always_ff @(posedge clk) begin
    if (strobe.clearAll)
      pcReg <= '0;
    else if (strobe.incPc)
      pcReg <= pcReg + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strobe.clearAll) begin
      opcodeOut  <= '0;
      operandOut <= '0;
    end else begin
      if (strobe.loadOpc) opcodeOut  <= busIn;
      if (strobe.loadOpr) operandOut <= busIn;
    end
  end

  // Split the address into bus-sized pieces, lowest first.
  for (genvar g = 0; g < ADDR_NIBS; g++) begin : g_nib
    assign pcNib[g] = pcReg[g*NIB_W +: NIB_W];
  end

  always_comb begin
    busOut = '0;
    for (int i = 0; i < ADDR_NIBS; i++)
      if (strobe.driveEn && strobe.nibIdx == 4'(i))
        busOut = pcNib[i];
  end
endmodule

// File: rtl/fetch_seq_top.sv
`timescale 1ns/1ps
module fetch_seq_top
  import fetch_seq_pkg::*;
#(
  parameter  int NIB_W       = 4,
  parameter  int ADDR_W      = 12,
  parameter  int SLOTS       = 8,
  parameter  int HOLD_CYCLES = 8,
  localparam int PH_W        = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rstReq,
  input  logic [NIB_W-1:0] busIn,
  output logic [NIB_W-1:0] busOut,
  output logic             busOe,
  output logic             syncOut,
  output logic [NIB_W-1:0] opcodeOut,
  output logic [NIB_W-1:0] operandOut,
  output logic [PH_W-1:0]  phaseOut
);
  localparam int ADDR_NIBS = ADDR_W / NIB_W;
  localparam int HOLD_CLKS = HOLD_CYCLES * SLOTS;

  seqStrobe_t strobe;

  fetch_seq_ctrl #(
    .SLOTS(SLOTS), .ADDR_NIBS(ADDR_NIBS), .HOLD_CLKS(HOLD_CLKS), .PH_W(PH_W)
  ) u_ctrl (
    .clk(clk), .rstReq(rstReq), .strobe(strobe), .phase(phaseOut), .syncOut(syncOut)
  );

  fetch_seq_dpath #(
    .NIB_W(NIB_W), .ADDR_W(ADDR_W), .ADDR_NIBS(ADDR_NIBS)
  ) u_dpath (
    .clk(clk), .strobe(strobe), .busIn(busIn), .busOut(busOut),
    .opcodeOut(opcodeOut), .operandOut(operandOut)
  );

  assign busOe = strobe.driveEn;
endmodule

// File: rtl/fetch_seq_chk.sv
`timescale 1ns/1ps
module fetch_seq_chk #(
  parameter int NIB_W     = 4,
  parameter int SLOTS     = 8,
  parameter int ADDR_NIBS = 3,
  parameter int PH_W      = 3
) (
  input logic             clk,
  input logic             rstReq,
  input logic             busOe,
  input logic             syncOut,
  input logic [NIB_W-1:0] opcodeOut,
  input logic [NIB_W-1:0] operandOut,
  input logic [PH_W-1:0]  phaseOut
);
  logic pastValid = 1'b0;
  always_ff @(posedge clk) pastValid <= 1'b1;

  // R1
  phase_step_chk: assert property (@(posedge clk) disable iff (rstReq || !pastValid)
    !$past(rstReq) |-> int'(phaseOut) == (int'($past(phaseOut)) + 1) % SLOTS);

  // R2
  sync_pulse_chk: assert property (@(posedge clk) disable iff (!pastValid)
    syncOut |=> !syncOut);

  // R2
  sync_next_addr_chk: assert property (@(posedge clk) disable iff (rstReq || !pastValid)
    $past(syncOut) |-> (busOe && phaseOut == '0));

  // R3
  drive_window_chk: assert property (@(posedge clk) disable iff (!pastValid)
    busOe |-> (int'(phaseOut) < ADDR_NIBS && !rstReq));

  // R9
  idle_in_reset_chk: assert property (@(posedge clk) disable iff (!pastValid)
    rstReq |-> (!busOe && !syncOut));

  // R5
  opcode_hold_chk: assert property (@(posedge clk) disable iff (rstReq || !pastValid)
    (!$past(rstReq) && int'($past(phaseOut)) != ADDR_NIBS) |-> $stable(opcodeOut));

  // R5
  operand_hold_chk: assert property (@(posedge clk) disable iff (rstReq || !pastValid)
    (!$past(rstReq) && int'($past(phaseOut)) != ADDR_NIBS + 1) |-> $stable(operandOut));
endmodule

bind fetch_seq_top fetch_seq_chk #(
  .NIB_W(NIB_W), .SLOTS(SLOTS), .ADDR_NIBS(ADDR_NIBS), .PH_W(PH_W)
) u_chk (
  .clk(clk), .rstReq(rstReq), .busOe(busOe), .syncOut(syncOut),
  .opcodeOut(opcodeOut), .operandOut(operandOut), .phaseOut(phaseOut)
);

// File: tb/fetch_seq_top_tb.sv
`timescale 1ns/1ps
module fetch_seq_top_tb;
  logic       clk = 1'b0;
  logic       rstReq = 1'b0;
  logic [3:0] busIn = 4'h0;
  logic [3:0] busOut, opcodeOut, operandOut;
  logic       busOe, syncOut;
  logic [2:0] phaseOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  fetch_seq_top u_dut (
    .clk(clk), .rstReq(rstReq), .busIn(busIn), .busOut(busOut), .busOe(busOe),
    .syncOut(syncOut), .opcodeOut(opcodeOut), .operandOut(operandOut), .phaseOut(phaseOut)
  );

  // Behavioural reference state
  int  mPh = 0, mPc = 0, mOpc = 0, mOpr = 0, mCnt = 0;
  bit  modelOn = 1'b0;
  int  stepNo = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  endtask

  // Model update at each edge, inputs are stable there.
  always @(posedge clk) begin
    if (rstReq) begin
      if (mCnt == 63) begin
        mPc = 0; mOpc = 0; mOpr = 0; mPh = 7; modelOn = 1'b1;
      end
      if (mCnt < 64) mCnt++;
    end else begin
      mCnt = 0;
      if (mPh == 2) mPc = (mPc + 1) % 4096;
      if (mPh == 3) mOpc = int'(busIn);
      if (mPh == 4) mOpr = int'(busIn);
      mPh = (mPh + 1) % 8;
    end
  end

  // Memory-side nibble pattern, changed just after each edge.
  always @(posedge clk) begin
    #1;
    stepNo++;
    busIn = 4'((stepNo * 7 + 3) ^ (stepNo >> 3));
  end

  // Full comparison every clock, away from the edge.
  always @(negedge clk) begin
    if (modelOn) begin
      bit expSync, expOe;
      expSync = !rstReq && mPh == 7;
      expOe   = !rstReq && mPh < 3;
      check(int'(phaseOut) == mPh, "R1 phase", int'(phaseOut), mPh);
      check(syncOut == expSync, "R2/R9 sync", int'(syncOut), int'(expSync));
      check(busOe == expOe, "R3/R9 drive enable", int'(busOe), int'(expOe));
      if (expOe)
        check(int'(busOut) == ((mPc >> (4 * mPh)) & 15), "R3/R4 address nibble",
              int'(busOut), (mPc >> (4 * mPh)) & 15);
      check(int'(opcodeOut) == mOpc, "R5 opcode", int'(opcodeOut), mOpc);
      check(int'(operandOut) == mOpr, "R5 operand", int'(operandOut), mOpr);
    end
  end

  task automatic setRst(input bit v);
    @(posedge clk); #1 rstReq = v;
  endtask

  task automatic waitPhase(input int p);
    do @(negedge clk); while (int'(phaseOut) != p);
  endtask

  initial begin
    #(4 * 200000);
    check(1'b0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    int sPh, sOpc, sOpr;
    repeat (2) @(posedge clk);
    #1 rstReq = 1'b1;
    repeat (70) @(posedge clk);
    #1 rstReq = 1'b0;
    // R6: sync first, then address zero
    @(negedge clk);
    check(syncOut && phaseOut == 3'd7, "R6 sync after clear", int'(phaseOut), 7);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(busOe && busOut == 4'h0, "R6 address zero", int'(busOut), 0);
    end
    repeat (400) @(posedge clk);

    // R7: 63-edge pulse from phase 5 clears nothing
    waitPhase(5);
    sPh = int'(phaseOut); sOpc = int'(opcodeOut); sOpr = int'(operandOut);
    #1 rstReq = 1'b1;
    repeat (63) @(posedge clk);
    #1 rstReq = 1'b0;
    @(negedge clk);
    check(int'(phaseOut) == sPh, "R7 phase kept", int'(phaseOut), sPh);
    check(int'(opcodeOut) == sOpc, "R7 opcode kept", int'(opcodeOut), sOpc);
    check(int'(operandOut) == sOpr, "R7 operand kept", int'(operandOut), sOpr);
    repeat (100) @(posedge clk);

    // R8: two 40-edge pulses split by one low edge
    waitPhase(5);
    sOpc = int'(opcodeOut);
    #1 rstReq = 1'b1;
    repeat (40) @(posedge clk);
    #1 rstReq = 1'b0;
    @(posedge clk); #1 rstReq = 1'b1;
    repeat (40) @(posedge clk);
    #1 rstReq = 1'b0;
    @(negedge clk);
    check(int'(phaseOut) == 6, "R8 no clear from split pulses", int'(phaseOut), 6);
    check(int'(opcodeOut) == sOpc, "R8 opcode kept", int'(opcodeOut), sOpc);

    // R4: free run past the address wrap
    repeat (4100 * 8) @(posedge clk);

    // R6: exactly 64 edges clears
    waitPhase(5);
    #1 rstReq = 1'b1;
    repeat (64) @(posedge clk);
    #1 rstReq = 1'b0;
    @(negedge clk);
    check(int'(phaseOut) == 7 && syncOut, "R6 clear at 64 edges", int'(phaseOut), 7);
    check(opcodeOut == 4'h0 && operandOut == 4'h0, "R6 nibbles cleared",
          int'(opcodeOut), 0);
    @(negedge clk);
    check(busOe && busOut == 4'h0, "R6 restart at address zero", int'(busOut), 0);
    repeat (50) @(posedge clk);
    @(negedge clk);
    finishRun();
  end
endmodule